// File: doc/BRIEF.md
# Programmable Interval Countdown Timer

This block is the per-core interval timer of a local interrupt controller. Software programs it through a small register port with three registers: a divide configuration, an initial count and a read-only current count. A free-running prescaler divides the core clock by a power of two. The ratio comes from a 3-bit code that is spread over register bits 3, 1 and 0. Each prescaled tick lowers the current count by one.

Writing the initial count loads the countdown and restarts the prescaler at once. When the count reaches zero, the block raises a one-cycle expiry pulse unless the mask input is high. In one-shot mode the count then stays at zero. In periodic mode it reloads from the initial count on the next tick. The mode and mask come in as plain inputs, and the pulse goes out as a plain output. Delivering the interrupt to a core is the job of the surrounding logic.

Top module: `intv_timer`

## Requirements
- R1: Register map on `wr_addr`/`rd_addr`: 0 = divide configuration, 1 = initial count, 2 = current count, 3 = unused (reads 0, writes ignored). All registers are 0 after reset and `expire_pulse` is low. The read data is combinational from `rd_addr`.
- R2: A write to the divide configuration keeps only bits 3, 1 and 0 (mask 0xB). Every other bit reads back as 0.
- R3: The divide code is {bit3, bit1, bit0}. The shift is (code + 1) mod 8 and the ratio is 2^shift, so code 7 (value 0xB) divides by 1, code 0 divides by 2 and code 6 (value 0xA) divides by 128.
- R4: A write to the initial count stores all 32 bits and loads the current count with that value on the same edge. It restarts the prescaler at the configured ratio, so the first decrement comes one full ratio of cycles after the write edge. The write wins over a terminal tick in the same cycle, and no pulse is raised for that tick.
- R5: The current count is read-only. Writes to address 2 or address 3 change no register.
- R6: While the current count is nonzero, it decreases by exactly one per prescaled tick.
- R7: When a tick takes the count from 1 to 0, `expire_pulse` is high for exactly the one cycle in which the count first reads 0. In one-shot mode (`periodic_mode` = 0) the count then stays at 0.
- R8: With `irq_mask` high in the cycle of that tick, no pulse is raised. The count still behaves the same.
- R9: In periodic mode, a tick that finds the count at 0 reloads it from the initial count, which gives a period of initial + 1 ticks.
- R10: Writing an initial count of 0 stops the timer. The current count reads 0, no pulse is raised and nothing reloads, even in periodic mode.
- R11: A divide configuration write does not change the current count. The new ratio takes effect at the prescaler wrap that follows the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 32 | Read data for `rd_addr` |
| periodic_mode | input | 1 | 1 = periodic reload, 0 = one-shot |
| irq_mask | input | 1 | 1 = suppress the expiry pulse |
| expire_pulse | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
A software reload of the initial count and the terminal tick that would expire the countdown can fall on the same clock edge. The bench sets divide-by-1 and loads a count of 3. It then issues a new initial-count write timed to land on the edge where the count would go from 1 to 0. Two results are checked in the following cycle: the count must show the newly written value, and the expiry pulse must stay low. A bound property also checks, after every initial-count write, that the count equals the written data and that no pulse follows.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;

  localparam int CNT_W     = 32;
  localparam int CFG_W     = 4;
  localparam int SHIFT_W   = 3;
  localparam int MAX_SHIFT = (1 << SHIFT_W) - 1;
  localparam int PRE_W     = MAX_SHIFT;

  localparam logic [CFG_W-1:0] CFG_KEEP = 4'hB;

  typedef enum logic [1:0] {
    REG_DIV  = 2'd0,
    REG_INIT = 2'd1,
    REG_CUR  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // Pack the divide code from its split bits and turn it into a shift amount.
  function automatic logic [SHIFT_W-1:0] cfg_to_shift(input logic [CFG_W-1:0] cfg);
    logic [SHIFT_W-1:0] code;
    code = {cfg[3], cfg[1:0]};
    return code + SHIFT_W'(1);
  endfunction

  // Highest prescaler value for a given shift (ratio - 1).
  function automatic logic [PRE_W-1:0] shift_to_limit(input logic [SHIFT_W-1:0] sh);
    logic [PRE_W:0] ratio;
    ratio = (PRE_W+1)'(1) << sh;
    return PRE_W'(ratio - (PRE_W+1)'(1));
  endfunction

endpackage

// File: rtl/intv_timer_regs.sv
module intv_timer_regs
  import intv_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CFG_W-1:0] cfg_q,
  output logic [CNT_W-1:0] init_q,
  output logic             init_wr
);

  logic cfg_wr;

  assign cfg_wr  = wr_en && (reg_sel_e'(wr_addr) == REG_DIV);
  assign init_wr = wr_en && (reg_sel_e'(wr_addr) == REG_INIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_wr) begin
      cfg_q <= wr_data[CFG_W-1:0] & CFG_KEEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= '0;
    end else if (init_wr) begin
      init_q <= wr_data;
    end
  end

endmodule

// File: rtl/intv_timer_presc.sv
module intv_timer_presc
  import intv_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] cfg_shift,
  output logic               tick
);

  logic [PRE_W-1:0]   pre_cnt;
  logic [SHIFT_W-1:0] act_shift;
  logic [PRE_W-1:0]   limit;

  assign limit = shift_to_limit(act_shift);
  assign tick  = (pre_cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt   <= '0;
      act_shift <= cfg_to_shift('0);
    end else if (restart) begin
      pre_cnt   <= '0;
      act_shift <= cfg_shift;
    end else if (tick) begin
      pre_cnt   <= '0;
      act_shift <= cfg_shift;
    end else begin
      pre_cnt   <= pre_cnt + PRE_W'(1);
    end
  end

endmodule

// File: rtl/intv_timer_count.sv
module intv_timer_count
  import intv_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_wr,
  input  logic [CNT_W-1:0] init_data,
  input  logic [CNT_W-1:0] init_q,
  input  logic             tick,
  input  logic             periodic_mode,
  input  logic             irq_mask,
  output logic [CNT_W-1:0] cur_q,
  output logic             expire_q
);

  logic at_zero;
  logic hit_zero;
  logic reload;

  assign at_zero  = (cur_q == '0);
  assign hit_zero = tick && !init_wr && (cur_q == CNT_W'(1));
  assign reload   = tick && !init_wr && at_zero && periodic_mode && (init_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (init_wr) begin
      cur_q <= init_data;
    end else if (reload) begin
      cur_q <= init_q;
    end else if (tick && !at_zero) begin
      cur_q <= cur_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      expire_q <= 1'b0;
    end else begin
      expire_q <= hit_zero && !irq_mask;
    end
  end

endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import intv_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             periodic_mode,
  input  logic             irq_mask,
  output logic             expire_pulse
);

  logic [CFG_W-1:0]   cfg_q;
  logic [CNT_W-1:0]   init_q;
  logic [CNT_W-1:0]   cur_q;
  logic               init_wr;
  logic               tick;
  logic [SHIFT_W-1:0] cfg_shift;

  assign cfg_shift = cfg_to_shift(cfg_q);

  intv_timer_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg_q   (cfg_q),
    .init_q  (init_q),
    .init_wr (init_wr)
  );

  intv_timer_presc u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (init_wr),
    .cfg_shift (cfg_shift),
    .tick      (tick)
  );

  intv_timer_count u_count (
    .clk           (clk),
    .rst_n         (rst_n),
    .init_wr       (init_wr),
    .init_data     (wr_data),
    .init_q        (init_q),
    .tick          (tick),
    .periodic_mode (periodic_mode),
    .irq_mask      (irq_mask),
    .cur_q         (cur_q),
    .expire_q      (expire_pulse)
  );

  always_comb begin
    unique case (reg_sel_e'(rd_addr))
      REG_DIV:  rd_data = {{(CNT_W-CFG_W){1'b0}}, cfg_q};
      REG_INIT: rd_data = init_q;
      REG_CUR:  rd_data = cur_q;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/intv_timer_chk.sv
module intv_timer_chk
  import intv_timer_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             init_wr,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] cur,
  input logic [CNT_W-1:0] init_val,
  input logic             expire,
  input logic             irq_mask
);

  // R4: a reload write sets the count and wins over any same-edge expiry
  a_r4_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> (cur == $past(wr_data)) && !expire);

  // R5: the count moves only on a tick or a reload write
  a_r5_cur_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    !init_wr && !tick |=> $stable(cur));

  // R6: one step down per tick while nonzero
  a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !init_wr && (cur != '0) |=> cur == $past(cur) - CNT_W'(1));

  // R7: pulse only while the count reads zero, never two in a row
  a_r7_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (cur == '0));
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);

  // R8: a masked terminal tick raises nothing
  a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |=> !expire);

  // R10: a zero initial count keeps the count parked at zero
  a_r10_zero_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (init_val == '0) && (cur == '0) && !init_wr |=> (cur == '0) && !expire);

endmodule

bind intv_timer intv_timer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .init_wr  (init_wr),
  .wr_data  (wr_data),
  .cur      (cur_q),
  .init_val (init_q),
  .expire   (expire_pulse),
  .irq_mask (irq_mask)
);

// File: tb/intv_timer_tb.sv
`timescale 1ns/1ps
module intv_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data;
  logic        periodic_mode = 1'b0;
  logic        irq_mask = 1'b0;
  logic        expire_pulse;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  intv_timer u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .periodic_mode (periodic_mode),
    .irq_mask      (irq_mask),
    .expire_pulse  (expire_pulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic step_count(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (expire_pulse) pulses++;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic int ratio_of(input int code);
    return 1 << ((code + 1) & 7);
  endfunction

  function automatic logic [31:0] cfg_of(input int code);
    return {28'd0, code[2], 1'b0, code[1:0]};
  endfunction

  task automatic park();
    periodic_mode = 1'b0; irq_mask = 1'b0;
    wr(2'd1, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check($sformatf("R1 reset reg%0d", a), v, 32'd0);
    end
    check("R1 reset pulse", {31'd0, expire_pulse}, 32'd0);
  endtask

  task automatic t_cfg_mask();
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v);
    check("R2 cfg keeps 0xB", v, 32'hB);
    wr(2'd0, 32'h0000_0074);
    rd(2'd0, v);
    check("R2 cfg drops bit2", v, 32'h0);
    wr(2'd3, 32'h1234_5678);
    rd(2'd3, v);
    check("R1 addr3 reads 0", v, 32'd0);
  endtask

  task automatic t_decode();
    logic [31:0] v;
    for (int c = 0; c < 8; c++) begin
      int r;
      r = ratio_of(c);
      wr(2'd0, cfg_of(c));
      wr(2'd1, 32'd100);
      step(3 * r - 1);
      rd(2'd2, v);
      check($sformatf("R3 code%0d before tick", c), v, 32'd98);
      step(1);
      rd(2'd2, v);
      check($sformatf("R3 code%0d after 3 ratios", c), v, 32'd97);
    end
    park();
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    wr(2'd0, 32'hA);
    wr(2'd1, 32'd20);
    wr(2'd2, 32'd5);
    wr(2'd3, 32'd7);
    rd(2'd2, v);
    check("R5 cur write ignored", v, 32'd20);
    rd(2'd1, v);
    check("R5 init untouched", v, 32'd20);
    rd(2'd0, v);
    check("R5 cfg untouched", v, 32'hA);
    step(126);
    rd(2'd2, v);
    check("R6 first tick at 128", v, 32'd19);
    park();
  endtask

  task automatic t_restart();
    logic [31:0] v;
    wr(2'd0, 32'hB);
    wr(2'd1, 32'd1000);
    step(10);
    rd(2'd2, v);
    check("R6 ten ticks", v, 32'd990);
    wr(2'd1, 32'd500);
    rd(2'd2, v);
    check("R4 reload on write", v, 32'd500);
    step(3);
    rd(2'd2, v);
    check("R4 count after restart", v, 32'd497);
    wr(2'd1, 32'hFFFF_FFF0);
    rd(2'd1, v);
    check("R4 init full width", v, 32'hFFFF_FFF0);
    step(2);
    rd(2'd2, v);
    check("R4 large count", v, 32'hFFFF_FFEE);
    park();
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    int p;
    wr(2'd0, 32'hB);
    wr(2'd1, 32'd5);
    step(4);
    rd(2'd2, v);
    check("R7 count at 1", v, 32'd1);
    check("R7 no early pulse", {31'd0, expire_pulse}, 32'd0);
    step(1);
    rd(2'd2, v);
    check("R7 count at 0", v, 32'd0);
    check("R7 pulse on zero", {31'd0, expire_pulse}, 32'd1);
    step_count(15, p);
    check("R7 single pulse", 32'(p), 32'd0);
    rd(2'd2, v);
    check("R7 one-shot stays 0", v, 32'd0);
    park();
  endtask

  task automatic t_masked();
    logic [31:0] v;
    int p;
    irq_mask = 1'b1;
    wr(2'd0, 32'hB);
    wr(2'd1, 32'd5);
    step_count(20, p);
    check("R8 masked no pulse", 32'(p), 32'd0);
    rd(2'd2, v);
    check("R8 masked count 0", v, 32'd0);
    park();
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    int p;
    periodic_mode = 1'b1;
    wr(2'd0, 32'hB);
    wr(2'd1, 32'd3);
    step_count(12, p);
    check("R9 three periods", 32'(p), 32'd3);
    rd(2'd2, v);
    check("R9 reloaded", v, 32'd3);
    park();
  endtask

  task automatic t_zero_stop();
    logic [31:0] v;
    int p;
    periodic_mode = 1'b1;
    wr(2'd0, 32'hB);
    wr(2'd1, 32'd50);
    step(5);
    rd(2'd2, v);
    check("R6 count 45", v, 32'd45);
    wr(2'd1, 32'd0);
    rd(2'd2, v);
    check("R10 zero write stops", v, 32'd0);
    step_count(30, p);
    check("R10 no pulse", 32'(p), 32'd0);
    rd(2'd2, v);
    check("R10 no reload", v, 32'd0);
    park();
  endtask

  task automatic t_div_change();
    logic [31:0] v;
    wr(2'd0, 32'hB);
    wr(2'd1, 32'd1000);
    step(10);
    wr(2'd0, 32'h1);
    rd(2'd2, v);
    check("R11 no restart", v, 32'd989);
    step(40);
    rd(2'd2, v);
    check("R11 new ratio pending", v, 32'd979);
    step(1);
    rd(2'd2, v);
    check("R11 new ratio 4", v, 32'd978);
    park();
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(2'd0, 32'hB);
    wr(2'd1, 32'd3);
    step(2);
    wr(2'd1, 32'd7);
    rd(2'd2, v);
    check("R4 write beats terminal", v, 32'd7);
    check("R4 no pulse on collide", {31'd0, expire_pulse}, 32'd0);
    park();
  endtask

  initial begin
    step(4);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_cfg_mask();
    t_decode();
    t_readonly();
    t_restart();
    t_oneshot();
    t_masked();
    t_periodic();
    t_zero_stop();
    t_div_change();
    t_collide();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule